// File: doc/BRIEF.md
# Edge-Capture Timer with Wrap Flag

The block holds a free-running 16-bit up-counter and one capture channel that watches an external pin. When the pin shows the selected transition, the counter value at that moment is latched into a capture register and a capture flag is raised. When the counter rolls over from its maximum to zero, a wrap flag is raised. Software counts these wraps to measure pulses longer than one counter period, which is 65536 ticks.

All control, flags and read-back go through a small word-wide register bus. Writes take effect on the clock edge at which `bus_we_i` is high. Reads are combinational from `bus_addr_i`. Both flags are cleared by writing a one to their bit. Each flag has its own enable, which gates it onto an interrupt output.

Register map (16-bit words):
- Address 0 is control. Bit 0 starts the counter. Bits 2:1 hold the edge code. Bit 3 enables the capture interrupt. Bit 7 enables the wrap interrupt. All other bits read as zero.
- Address 1 holds the capture flag in bit 0.
- Address 2 holds the wrap flag in bit 7.
- Address 3 holds the counter.
- Address 4 holds the capture register.

Top module: `capture_timer`

## Requirements
- R1: After reset, the counter, the capture register, the control register, both flags and both interrupt outputs are zero.
- R2: While control bit 0 is 1, the counter (address 3) goes up by exactly one per clock. While it is 0, the counter holds its value.
- R3: On a running clock where the counter is 0xFFFF, the counter becomes 0 and the wrap flag (address 2, bit 7) is set.
- R4: With edge code 01 (control bits 2:1), a low-to-high pin transition stores the counter in the capture register and sets the capture flag (address 1, bit 0). A high-to-low transition does not.
- R5: With edge code 10, only a high-to-low pin transition captures. A low-to-high transition leaves the flag clear.
- R6: With edge code 00, pin transitions change neither the capture register nor the capture flag.
- R7: With edge code 11, both pin transitions capture.
- R8: Writing 1 to bit 0 of address 1 clears the capture flag. Writing 0 there leaves the flag unchanged.
- R9: Writing 1 to bit 7 of address 2 clears the wrap flag. Writing 0 leaves it unchanged. `ovf_irq_o` is high exactly when the wrap flag and control bit 7 are both 1.
- R10: `cap_irq_o` is high exactly when the capture flag and control bit 3 are both 1.
- R11: If a capture and a clearing write to the capture flag fall on the same clock, the flag ends up set.
- R12: The pin passes through a two-stage synchronizer before edge detection. The captured value equals the counter value visible on the bus in the cycle in which the pin changed, plus two, while the counter runs.
- R13: Writes to addresses 3 and 4 are ignored. The counter and the capture register read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Asynchronous capture pin |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for `bus_addr_i` |
| cap_irq_o | output | 1 | Capture interrupt |
| ovf_irq_o | output | 1 | Wrap interrupt |

## Verification
The flags and the capture register are internal state that is visible only through the bus and the two interrupt lines. A bench reference model is compared against the read port and both interrupt outputs on every clock, so any divergence in the counter, the flags or the captured value shows up at the first clock after the faulty update. A wrong synchronizer depth or edge polarity shows up as a captured value off by a few counts, or as a flag that never rises, about five clocks after a pin change. One full counter period is run so that a faulty wrap detection appears at the 65536th clock.

// File: rtl/ict_pkg.sv
package ict_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  localparam int unsigned REG_CTRL  = 0;
  localparam int unsigned REG_CAPF  = 1;
  localparam int unsigned REG_OVFF  = 2;
  localparam int unsigned REG_COUNT = 3;
  localparam int unsigned REG_CAPT  = 4;

  localparam int unsigned RUN_BIT    = 0;
  localparam int unsigned SEL_LSB    = 1;
  localparam int unsigned CAP_IE_BIT = 3;
  localparam int unsigned OVF_IE_BIT = 7;
  localparam int unsigned CAPF_BIT   = 0;
  localparam int unsigned OVFF_BIT   = 7;
endpackage

// File: rtl/ict_sync_edge.sv
module ict_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous sample
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign rise_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/ict_counter.sv
module ict_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = en_i & (&cnt_q);
endmodule

// File: rtl/ict_capture.sv
module ict_capture
  import ict_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  edge_sel_e    sel_i,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic [W-1:0] cnt_i,
  output logic         hit_o,
  output logic [W-1:0] cap_o
);
  logic [W-1:0] cap_q;

  always_comb begin
    unique case (sel_i)
      EDGE_RISE: hit_o = rise_i;
      EDGE_FALL: hit_o = fall_i;
      EDGE_ANY:  hit_o = rise_i | fall_i;
      default:   hit_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cap_q <= '0;
    else if (hit_o) cap_q <= cnt_i;
  end

  assign cap_o = cap_q;
endmodule

// File: rtl/capture_timer.sv
module capture_timer
  import ict_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  output logic              cap_irq_o,
  output logic              ovf_irq_o
);
  localparam int unsigned DATA_W = CNT_W;
  localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'((1 << RUN_BIT) | (3 << SEL_LSB) |
                                                    (1 << CAP_IE_BIT) | (1 << OVF_IE_BIT));

  logic [DATA_W-1:0] ctrl_q;
  logic              cap_flag_q, ovf_flag_q;
  logic              rise, fall, hit, wrap;
  logic [CNT_W-1:0]  cnt, cap;
  logic              run_en, cap_ie, ovf_ie;
  edge_sel_e         edge_sel;
  logic              wr_ctrl, clr_cap, clr_ovf;

  assign run_en   = ctrl_q[RUN_BIT];
  assign cap_ie   = ctrl_q[CAP_IE_BIT];
  assign ovf_ie   = ctrl_q[OVF_IE_BIT];
  assign edge_sel = edge_sel_e'(ctrl_q[SEL_LSB +: 2]);

  assign wr_ctrl = bus_we_i && (bus_addr_i == ADDR_W'(REG_CTRL));
  assign clr_cap = bus_we_i && (bus_addr_i == ADDR_W'(REG_CAPF)) && bus_wdata_i[CAPF_BIT];
  assign clr_ovf = bus_we_i && (bus_addr_i == ADDR_W'(REG_OVFF)) && bus_wdata_i[OVFF_BIT];

  ict_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .rise_o(rise), .fall_o(fall)
  );

  ict_counter #(.W(CNT_W)) i_cnt (
    .clk_i, .rst_ni, .en_i(run_en), .cnt_o(cnt), .wrap_o(wrap)
  );

  ict_capture #(.W(CNT_W)) i_cap (
    .clk_i, .rst_ni, .sel_i(edge_sel), .rise_i(rise), .fall_i(fall),
    .cnt_i(cnt), .hit_o(hit), .cap_o(cap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= bus_wdata_i & CTRL_MASK;
  end

  // set takes priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_flag_q <= 1'b0;
      ovf_flag_q <= 1'b0;
    end else begin
      if (hit)          cap_flag_q <= 1'b1;
      else if (clr_cap) cap_flag_q <= 1'b0;
      if (wrap)         ovf_flag_q <= 1'b1;
      else if (clr_ovf) ovf_flag_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      ADDR_W'(REG_CTRL):  bus_rdata_o = ctrl_q;
      ADDR_W'(REG_CAPF):  bus_rdata_o[CAPF_BIT] = cap_flag_q;
      ADDR_W'(REG_OVFF):  bus_rdata_o[OVFF_BIT] = ovf_flag_q;
      ADDR_W'(REG_COUNT): bus_rdata_o = cnt;
      ADDR_W'(REG_CAPT):  bus_rdata_o = cap;
      default:            bus_rdata_o = '0;
    endcase
  end

  assign cap_irq_o = cap_flag_q & cap_ie;
  assign ovf_irq_o = ovf_flag_q & ovf_ie;
endmodule

// File: rtl/ict_checker.sv
module ict_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic [1:0]       sel_i,
  input logic             hit_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] cap_i,
  input logic             cap_flag_i,
  input logic             ovf_flag_i,
  input logic             cap_irq_i,
  input logic             ovf_irq_i
);
  // R2
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> cnt_i == CNT_W'($past(cnt_i) + 1'b1));

  // R2
  count_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_i));

  // R3
  wrap_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && (&cnt_i)) |=> ovf_flag_i);

  // R4
  capture_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_i |=> $stable(cap_i));

  // R6
  sel_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 2'b00) |-> !hit_i);

  // R11
  cap_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> cap_flag_i && (cap_i == $past(cnt_i)));

  // R9
  ovf_irq_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovf_flag_i) |-> !ovf_irq_i);

  // R10
  cap_irq_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cap_flag_i) |-> !cap_irq_i);
endmodule

bind capture_timer ict_checker #(.CNT_W(CNT_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run_i      (run_en),
  .sel_i      (edge_sel),
  .hit_i      (hit),
  .cnt_i      (cnt),
  .cap_i      (cap),
  .cap_flag_i (cap_flag_q),
  .ovf_flag_i (ovf_flag_q),
  .cap_irq_i  (cap_irq_o),
  .ovf_irq_i  (ovf_irq_o)
);

// File: tb/test_capture_timer.sv
`timescale 1ns/1ps
module test_capture_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        cirq, oirq;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  capture_timer i_capture_timer (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .cap_irq_o(cirq), .ovf_irq_o(oirq)
  );

  // reference model state
  int m_run, m_sel, m_cie, m_oie, m_cnt, m_cap, m_cf, m_of;
  bit pq[$];

  function automatic logic [15:0] mread(logic [2:0] a);
    case (a)
      3'd0: return 16'((m_oie << 7) | (m_cie << 3) | (m_sel << 1) | m_run);
      3'd1: return 16'(m_cf);
      3'd2: return 16'(m_of << 7);
      3'd3: return 16'(m_cnt);
      3'd4: return 16'(m_cap);
      default: return 16'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_sel = 0; m_cie = 0; m_oie = 0;
      m_cnt = 0; m_cap = 0; m_cf = 0; m_of = 0;
      pq = '{0, 0, 0};
    end else begin
      bit s, p, hit, wrap;
      s = pq[pq.size()-2];
      p = pq[pq.size()-3];
      hit = (m_sel == 1 && s && !p) || (m_sel == 2 && !s && p) || (m_sel == 3 && s != p);
      wrap = m_run != 0 && m_cnt == 65535;
      if (hit) m_cap = m_cnt;
      if (hit) m_cf = 1;
      else if (we && addr == 3'd1 && wdata[0]) m_cf = 0;
      if (wrap) m_of = 1;
      else if (we && addr == 3'd2 && wdata[7]) m_of = 0;
      if (m_run != 0) m_cnt = (m_cnt + 1) % 65536;
      if (we && addr == 3'd0) begin
        m_run = wdata[0]; m_sel = wdata[2:1]; m_cie = wdata[3]; m_oie = wdata[7];
      end
      pq.push_back(pin);
      if (pq.size() > 4) void'(pq.pop_front());
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      chk({cur_req, " rdata"}, 32'(rdata), 32'(mread(addr)));
      chk({cur_req, " cap_irq"}, 32'(cirq), 32'(m_cf != 0 && m_cie != 0));
      chk({cur_req, " ovf_irq"}, 32'(oirq), 32'(m_of != 0 && m_oie != 0));
    end
  end

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] v);
    @(negedge clk); addr = a;
    @(posedge clk); #1; v = rdata;
  endtask

  task automatic set_pin(logic v);
    @(negedge clk); pin = v;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // change pin mid-cycle and return the count seen in that cycle
  task automatic pin_edge(logic v, output logic [15:0] c);
    @(negedge clk); addr = 3'd3;
    @(negedge clk); pin = v; #1; c = rdata;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [15:0] v, c0, c1;
    bit got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cur_req = "R1";
    rd(3'd0, v); chk("R1 ctrl", 32'(v), 0);
    rd(3'd3, v); chk("R1 count", 32'(v), 0);
    rd(3'd4, v); chk("R1 capture", 32'(v), 0);
    rd(3'd1, v); chk("R1 cap flag", 32'(v), 0);
    rd(3'd2, v); chk("R1 ovf flag", 32'(v), 0);
    chk("R1 irqs", 32'({cirq, oirq}), 0);

    cur_req = "R2";
    wr(3'd0, 16'h0001);
    rd(3'd3, c0); rd(3'd3, c1); chk("R2 step", 32'(c1), 32'(c0 + 16'd1));
    wr(3'd0, 16'h0000);
    rd(3'd3, c0); idle(4); rd(3'd3, c1); chk("R2 hold", 32'(c1), 32'(c0));

    cur_req = "R13";
    wr(3'd3, 16'h1234); wr(3'd4, 16'h5678);
    rd(3'd3, v); chk("R13 count", 32'(v), 32'(c1));
    rd(3'd4, v); chk("R13 capture", 32'(v), 0);

    cur_req = "R4";
    wr(3'd0, 16'h0003);
    pin_edge(1'b1, c0); idle(5);
    rd(3'd4, v); chk("R12 latency rise", 32'(v), 32'(c0 + 16'd2));
    rd(3'd1, v); chk("R4 flag set", 32'(v), 1);
    cur_req = "R8";
    wr(3'd1, 16'h0000); rd(3'd1, v); chk("R8 write 0 keeps", 32'(v), 1);
    wr(3'd1, 16'h0001); rd(3'd1, v); chk("R8 write 1 clears", 32'(v), 0);
    cur_req = "R4";
    set_pin(1'b0); idle(5);
    rd(3'd1, v); chk("R4 fall ignored", 32'(v), 0);

    cur_req = "R5";
    wr(3'd0, 16'h0005);
    set_pin(1'b1); idle(5);
    rd(3'd1, v); chk("R5 rise ignored", 32'(v), 0);
    pin_edge(1'b0, c0); idle(5);
    rd(3'd4, v); chk("R5 fall capture", 32'(v), 32'(c0 + 16'd2));
    rd(3'd1, v); chk("R5 flag set", 32'(v), 1);
    wr(3'd1, 16'h0001);

    cur_req = "R7";
    wr(3'd0, 16'h0007);
    pin_edge(1'b1, c0); idle(5);
    rd(3'd4, v); chk("R7 rise capture", 32'(v), 32'(c0 + 16'd2));
    wr(3'd1, 16'h0001);
    pin_edge(1'b0, c0); idle(5);
    rd(3'd4, v); chk("R7 fall capture", 32'(v), 32'(c0 + 16'd2));
    rd(3'd1, v); chk("R7 flag set", 32'(v), 1);
    wr(3'd1, 16'h0001);

    cur_req = "R6";
    wr(3'd0, 16'h0001);
    rd(3'd4, c1);
    set_pin(1'b1); idle(4); set_pin(1'b0); idle(5);
    rd(3'd4, v); chk("R6 capture unchanged", 32'(v), 32'(c1));
    rd(3'd1, v); chk("R6 flag clear", 32'(v), 0);

    cur_req = "R10";
    wr(3'd0, 16'h000B);
    set_pin(1'b1); idle(5);
    chk("R10 cap irq on", 32'(cirq), 1);
    wr(3'd0, 16'h0003); idle(1);
    chk("R10 cap irq gated", 32'(cirq), 0);
    wr(3'd1, 16'h0001);

    cur_req = "R11";
    set_pin(1'b0); idle(5);
    @(negedge clk); pin = 1'b1;
    @(negedge clk);
    @(negedge clk); we = 1'b1; addr = 3'd1; wdata = 16'h0001;
    @(negedge clk); we = 1'b0; wdata = '0;
    rd(3'd1, v); chk("R11 set wins", 32'(v), 1);
    wr(3'd1, 16'h0001);

    cur_req = "R3";
    wr(3'd0, 16'h0083);
    @(negedge clk); addr = 3'd3;
    got = 0;
    for (int i = 0; i < 70000 && !got; i++) begin
      @(posedge clk); #1;
      if (rdata == 16'hFFFF) got = 1;
    end
    chk("R3 reached max", 32'(got), 1);
    @(negedge clk); addr = 3'd2;
    @(posedge clk); #1;
    chk("R3 wrap flag", 32'(rdata), 32'h80);
    chk("R9 ovf irq on", 32'(oirq), 1);
    rd(3'd3, v); chk("R3 count wrapped", 32'(v), 1);
    cur_req = "R9";
    wr(3'd2, 16'h007F); rd(3'd2, v); chk("R9 write 0 keeps", 32'(v), 32'h80);
    wr(3'd2, 16'h0080); rd(3'd2, v); chk("R9 write 1 clears", 32'(v), 0);
    chk("R9 ovf irq off", 32'(oirq), 0);

    idle(2);
    summary();
  end
endmodule